// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block keeps a small mode register for an SDRAM-style memory controller and turns each read or write command into the stream of column addresses that the burst will touch. Software or a controller front end programs the register with a load strobe, a 2-bit register select and a 13-bit value. The register holds four settings: how long a burst is, whether the addresses within a burst count up or follow an XOR pattern, the read latency, and whether writes use the programmed length or are forced to one beat.

After a command the block presents one column address per clock while `busy` is high. Every burst stays inside an aligned block of columns whose size equals the burst length. The starting column picks the first beat, and the column bits above the block size stay constant. A full-page setting counts through all 512 columns until a terminate strobe arrives. The block also reports the effective read and write lengths and the read latency, and it raises a one-cycle error flag when a load would store an illegal combination. In that case the old settings remain.

Top module: `burst_col_seq`

## Requirements
- R1: A load takes effect only when `ld_en` is high and `ld_sel` is 2'b00. Any other select leaves the settings unchanged and raises no error. After reset the settings are: length code 3'b011 (8 beats), sequential order, latency code 3'b010, normal operating mode.
- R2: Value bits [2:0] are the length code: 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8 and 111 gives full page (512). `rd_len` reports the effective read length in beats, one cycle after the load edge.
- R3: Value bits [6:4] are the latency code. 010 makes `rd_latency` equal 2 and 011 makes it equal 3.
- R4: A load with select 00 raises `cfg_err` for exactly one cycle after the load edge, and keeps the previous settings, when any of these holds: the length code is 100, 101 or 110; the latency code is not 010 or 011; the mode field (bits [12:7]) is neither 000000 nor 000100; or the length code is 111 together with order bit [3] set.
- R5: A command (`cmd_rd` or `cmd_wr`) sampled at a clock edge makes `busy` high from the next cycle on. In that first cycle `col_out` equals the command's column. If both commands are high, the read wins.
- R6: In sequential order (bit [3] = 0) with a length of L beats, beat k has low log2(L) bits equal to (start + k) mod L. The upper bits stay those of the start column, so the burst wraps inside its aligned block.
- R7: In interleaved order (bit [3] = 1), beat k has low log2(L) bits equal to the start's low bits XOR k. The upper bits stay fixed.
- R8: In full-page mode beat k is (start + k) mod 512. The burst runs until `term` is sampled high, and `busy` is low in the cycle after that edge.
- R9: With a length of 1 the burst issues exactly one address, the start column. `busy` is high for one cycle.
- R10: With mode 000100, a write burst is one beat long and `wr_len` reads 1, while reads keep the programmed length. With mode 000000 `wr_len` equals `rd_len`.
- R11: A command that arrives while a burst is running ends that burst. The new sequence starts with its own start column in the next cycle.
- R12: A fixed-length burst keeps `busy` high for exactly L cycles. `term` sampled high during any burst ends it at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | 2 | Register select; only 00 addresses the mode register |
| ld_val | input | 13 | Value to load |
| cmd_rd | input | 1 | Read command |
| cmd_wr | input | 1 | Write command |
| cmd_col | input | 9 | Start column of the command |
| term | input | 1 | Ends the running burst |
| col_out | output | 9 | Column address of the current beat (zero when idle) |
| busy | output | 1 | High while burst addresses are being issued |
| rd_len | output | 10 | Effective read length in beats |
| wr_len | output | 10 | Effective write length in beats |
| rd_latency | output | 3 | Programmed read latency in clocks |
| cfg_err | output | 1 | One-cycle flag for a rejected load |

## Verification
Start columns are chosen at every position within the aligned block, so sequential wrap can be told apart from plain counting and from XOR ordering. Each length is exercised in both orders. Full-page bursts start near column 511 to expose modulo-512 wrap, and are cut off by `term` after random lengths. Random loads mix legal settings with raw values, which separates rejected codes from accepted ones. Directed cases cover a restart in mid-burst, an early terminate, and write bursts under the single-write mode against read bursts under the same mode.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  // Mode register layout, MSB first
  typedef struct packed {
    logic [5:0] opmode;
    logic [2:0] lat;
    logic       ilv;
    logic [2:0] blen;
  } mode_t;

  localparam logic [2:0] BL_FULL      = 3'b111;
  localparam logic [2:0] LAT_TWO      = 3'b010;
  localparam logic [2:0] LAT_THREE    = 3'b011;
  localparam logic [5:0] OP_NORMAL    = 6'b000000;
  localparam logic [5:0] OP_SINGLE_WR = 6'b000100;

  function automatic logic cfg_legal(input mode_t m);
    logic len_ok, lat_ok, op_ok, combo_ok;
    len_ok   = (m.blen[2] == 1'b0) || (m.blen == BL_FULL);
    lat_ok   = (m.lat == LAT_TWO) || (m.lat == LAT_THREE);
    op_ok    = (m.opmode == OP_NORMAL) || (m.opmode == OP_SINGLE_WR);
    combo_ok = !((m.blen == BL_FULL) && m.ilv);
    return len_ok && lat_ok && op_ok && combo_ok;
  endfunction

endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
  import bcs_pkg::*;
#(
  parameter int          MR_W    = 13,
  parameter logic [12:0] RST_VAL = 13'h0023
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_en,
  input  logic [1:0]      ld_sel,
  input  logic [MR_W-1:0] ld_val,
  output mode_t           cfg,
  output logic            cfg_err
);

  mode_t cfg_q, cfg_d;
  logic  err_q, err_d;
  logic  hit;
  mode_t cand;

  always_comb begin
    cand  = mode_t'(ld_val);
    hit   = ld_en && (ld_sel == 2'b00);
    cfg_d = cfg_q;
    err_d = 1'b0;
    if (hit) begin
      if (cfg_legal(cand)) cfg_d = cand;
      else                 err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= mode_t'(RST_VAL);
      err_q <= 1'b0;
    end else begin
      if (hit) cfg_q <= cfg_d;
      err_q <= err_d;
    end
  end

  assign cfg     = cfg_q;
  assign cfg_err = err_q;

endmodule

// File: rtl/bcs_len_decode.sv
module bcs_len_decode
  import bcs_pkg::*;
#(
  parameter int COL_W = 9,
  localparam int LEN_W = COL_W + 1
) (
  input  mode_t            cfg,
  output logic [LEN_W-1:0] rd_len,
  output logic [LEN_W-1:0] wr_len,
  output logic [COL_W-1:0] rd_mask,
  output logic [COL_W-1:0] wr_mask,
  output logic             rd_full,
  output logic             wr_full,
  output logic             ilv,
  output logic [2:0]       lat
);

  logic             full;
  logic             single;
  logic [1:0]       lg;
  logic [COL_W-1:0] prog_mask;
  logic [LEN_W-1:0] prog_len;

  always_comb begin
    full      = (cfg.blen == BL_FULL);
    single    = (cfg.opmode == OP_SINGLE_WR);
    lg        = cfg.blen[1:0];
    prog_mask = full ? {COL_W{1'b1}} : ~({COL_W{1'b1}} << lg);
    prog_len  = full ? (LEN_W'(1) << COL_W) : (LEN_W'(1) << lg);

    rd_len    = prog_len;
    rd_mask   = prog_mask;
    rd_full   = full;
    wr_len    = single ? LEN_W'(1) : prog_len;
    wr_mask   = single ? '0 : prog_mask;
    wr_full   = single ? 1'b0 : full;
    ilv       = cfg.ilv && !full;
    lat       = cfg.lat;
  end

endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_rd,
  input  logic             cmd_wr,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             term,
  input  logic [COL_W-1:0] rd_mask,
  input  logic [COL_W-1:0] wr_mask,
  input  logic             rd_full,
  input  logic             wr_full,
  input  logic             ilv,
  output logic [COL_W-1:0] col_out,
  output logic             busy,
  output logic [COL_W-1:0] bst_mask
);

  logic             act_q, act_d;
  logic [COL_W-1:0] base_q, base_d;
  logic [COL_W-1:0] k_q, k_d;
  logic [COL_W-1:0] mask_q, mask_d;
  logic             fp_q, fp_d;
  logic             ilv_q, ilv_d;
  logic             last;
  logic             cmd;
  logic [COL_W-1:0] low;

  // next-state
  always_comb begin
    cmd    = cmd_rd || cmd_wr;
    last   = !fp_q && (k_q == mask_q);
    act_d  = act_q;
    base_d = base_q;
    k_d    = k_q;
    mask_d = mask_q;
    fp_d   = fp_q;
    ilv_d  = ilv_q;
    if (cmd) begin
      act_d  = 1'b1;
      base_d = cmd_col;
      k_d    = '0;
      mask_d = cmd_rd ? rd_mask : wr_mask;
      fp_d   = cmd_rd ? rd_full : wr_full;
      ilv_d  = ilv;
    end else if (act_q) begin
      if (term || last) act_d = 1'b0;
      else              k_d   = k_q + 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      base_q <= '0;
      k_q    <= '0;
      mask_q <= '0;
      fp_q   <= 1'b0;
      ilv_q  <= 1'b0;
    end else begin
      act_q <= act_d;
      if (cmd || act_q) begin
        base_q <= base_d;
        k_q    <= k_d;
        mask_q <= mask_d;
        fp_q   <= fp_d;
        ilv_q  <= ilv_d;
      end
    end
  end

  // address of the current beat
  always_comb begin
    low     = ilv_q ? (base_q ^ k_q) : (base_q + k_q);
    col_out = act_q ? ((base_q & ~mask_q) | (low & mask_q)) : '0;
  end

  assign busy     = act_q;
  assign bst_mask = mask_q;

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int COL_W = 9,
  parameter int MR_W  = 13,
  localparam int LEN_W = COL_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [1:0]       ld_sel,
  input  logic [MR_W-1:0]  ld_val,
  input  logic             cmd_rd,
  input  logic             cmd_wr,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             term,
  output logic [COL_W-1:0] col_out,
  output logic             busy,
  output logic [LEN_W-1:0] rd_len,
  output logic [LEN_W-1:0] wr_len,
  output logic [2:0]       rd_latency,
  output logic             cfg_err
);

  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  mode_t            cfg;
  logic [COL_W-1:0] rd_mask, wr_mask, bst_mask;
  logic             rd_full, wr_full, ilv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  bcs_mode_reg #(.MR_W(MR_W)) u_mode (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ld_en   (ld_en),
    .ld_sel  (ld_sel),
    .ld_val  (ld_val),
    .cfg     (cfg),
    .cfg_err (cfg_err)
  );

  bcs_len_decode #(.COL_W(COL_W)) u_dec (
    .cfg     (cfg),
    .rd_len  (rd_len),
    .wr_len  (wr_len),
    .rd_mask (rd_mask),
    .wr_mask (wr_mask),
    .rd_full (rd_full),
    .wr_full (wr_full),
    .ilv     (ilv),
    .lat     (rd_latency)
  );

  bcs_addr_gen #(.COL_W(COL_W)) u_gen (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cmd_rd   (cmd_rd),
    .cmd_wr   (cmd_wr),
    .cmd_col  (cmd_col),
    .term     (term),
    .rd_mask  (rd_mask),
    .wr_mask  (wr_mask),
    .rd_full  (rd_full),
    .wr_full  (wr_full),
    .ilv      (ilv),
    .col_out  (col_out),
    .busy     (busy),
    .bst_mask (bst_mask)
  );

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
  parameter int COL_W = 9,
  localparam int LEN_W = COL_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_rd,
  input logic             cmd_wr,
  input logic [COL_W-1:0] cmd_col,
  input logic             term,
  input logic [COL_W-1:0] col_out,
  input logic             busy,
  input logic [LEN_W-1:0] rd_len,
  input logic [LEN_W-1:0] wr_len,
  input logic [2:0]       rd_latency,
  input logic             cfg_err,
  input logic [COL_W-1:0] bst_mask
);

  p_start_col_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd || cmd_wr) |=> (busy && col_out == $past(cmd_col)));

  p_err_keeps_cfg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (rd_len == $past(rd_len) && rd_latency == $past(rd_latency)));

  p_block_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(cmd_rd || cmd_wr))
      |-> (((col_out ^ $past(col_out)) & ~bst_mask) == '0));

  p_term_stop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && term && !cmd_rd && !cmd_wr) |=> !busy);

  p_lat_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_latency == 3'd2) || (rd_latency == 3'd3));

  p_single_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(cmd_wr && !cmd_rd && wr_len == LEN_W'(1)) && !cmd_rd && !cmd_wr)
      |=> !busy);

endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W)) u_bcs_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .cmd_rd     (cmd_rd),
  .cmd_wr     (cmd_wr),
  .cmd_col    (cmd_col),
  .term       (term),
  .col_out    (col_out),
  .busy       (busy),
  .rd_len     (rd_len),
  .wr_len     (wr_len),
  .rd_latency (rd_latency),
  .cfg_err    (cfg_err),
  .bst_mask   (bst_mask)
);

// File: tb/test_burst_col_seq.sv
`timescale 1ns/1ps
module test_burst_col_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_en;
  logic [1:0]  ld_sel;
  logic [12:0] ld_val;
  logic        cmd_rd, cmd_wr, term;
  logic [8:0]  cmd_col;
  logic [8:0]  col_out;
  logic        busy;
  logic [9:0]  rd_len, wr_len;
  logic [2:0]  rd_latency;
  logic        cfg_err;

  int n_tests = 0;
  int n_fail  = 0;
  logic [12:0] m_cfg;

  always #2.5 clk = ~clk;

  burst_col_seq i_burst_col_seq (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_val(ld_val),
    .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_col(cmd_col), .term(term),
    .col_out(col_out), .busy(busy), .rd_len(rd_len), .wr_len(wr_len),
    .rd_latency(rd_latency), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic bit legal(input logic [12:0] v);
    logic [2:0] bl = v[2:0];
    logic [2:0] cl = v[6:4];
    logic [5:0] op = v[12:7];
    return ((bl[2] == 1'b0) || bl == 3'b111) && (cl == 3'd2 || cl == 3'd3) &&
           (op == 6'd0 || op == 6'd4) && !(bl == 3'b111 && v[3]);
  endfunction

  function automatic int exp_rd_len(input logic [12:0] v);
    return (v[2:0] == 3'b111) ? 512 : (1 << v[1:0]);
  endfunction

  function automatic int exp_wr_len(input logic [12:0] v);
    return (v[12:7] == 6'd4) ? 1 : exp_rd_len(v);
  endfunction

  function automatic logic [8:0] exp_col(input logic [8:0] s, input int len,
                                          input bit il, input int k);
    logic [8:0] m = 9'(len - 1);
    logic [8:0] kk = 9'(k);
    logic [8:0] lo = il ? (s ^ kk) : (s + kk);
    return (s & ~m) | (lo & m);
  endfunction

  task automatic check_cfg(input string req);
    chk(rd_len == 10'(exp_rd_len(m_cfg)), req, rd_len, exp_rd_len(m_cfg));
    chk(wr_len == 10'(exp_wr_len(m_cfg)), req, wr_len, exp_wr_len(m_cfg));
    chk(rd_latency == m_cfg[6:4], req, rd_latency, m_cfg[6:4]);
  endtask

  task automatic load(input logic [1:0] sel, input logic [12:0] v, input string req);
    bit e;
    ld_en = 1'b1; ld_sel = sel; ld_val = v;
    tick();
    ld_en = 1'b0;
    e = (sel == 2'b00) && !legal(v);
    if (sel == 2'b00 && legal(v)) m_cfg = v;
    chk(cfg_err == e, req, cfg_err, e);
    check_cfg(req);
    tick();
    chk(cfg_err == 1'b0, req, cfg_err, 0);
  endtask

  // issue one command and follow it; nfp = beats before term in full page
  task automatic burst(input bit wr, input logic [8:0] col, input int nfp, input string req);
    int len = wr ? exp_wr_len(m_cfg) : exp_rd_len(m_cfg);
    bit il  = m_cfg[3] && (len != 512);
    int n   = (len == 512) ? nfp : len;
    cmd_rd = !wr; cmd_wr = wr; cmd_col = col;
    tick();
    cmd_rd = 1'b0; cmd_wr = 1'b0;
    for (int k = 0; k < n; k++) begin
      logic [8:0] e = exp_col(col, len, il, k);
      chk(busy == 1'b1, req, busy, 1);
      chk(col_out == e, req, col_out, e);
      if (len == 512 && k == n - 1) term = 1'b1;
      tick();
      term = 1'b0;
    end
    chk(busy == 1'b0, req, busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [12:0] v;
    int unsigned seed;
    seed = $urandom(32'd20240517);
    rst_n = 1'b0; ld_en = 1'b0; ld_sel = 2'b00; ld_val = '0;
    cmd_rd = 1'b0; cmd_wr = 1'b0; cmd_col = '0; term = 1'b0;
    m_cfg = 13'h0023;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1 reset state
    chk(busy == 1'b0, "R1 reset busy", busy, 0);
    chk(cfg_err == 1'b0, "R1 reset err", cfg_err, 0);
    check_cfg("R1 reset cfg");

    // R1 other selects ignored
    load(2'b01, 13'h0010, "R1 sel01 ignored");
    load(2'b11, 13'h0FFF, "R1 sel11 ignored");

    // R6 sequential wrap, length 8
    burst(1'b0, 9'h1AD, 0, "R6 seq8 wrap");
    // R12 write length equals read length
    burst(1'b1, 9'h007, 0, "R12 seq8 write");

    // R7 interleaved
    load(2'b00, 13'h002B, "R2 ilv8 load");
    burst(1'b0, 9'h1AD, 0, "R7 ilv8");
    load(2'b00, 13'h002A, "R2 ilv4 load");
    burst(1'b0, 9'h0F6, 0, "R7 ilv4");
    load(2'b00, 13'h0022, "R2 seq4 load");
    burst(1'b1, 9'h0F6, 0, "R6 seq4");
    load(2'b00, 13'h0029, "R2 ilv2 load");
    burst(1'b0, 9'h033, 0, "R7 ilv2");

    // R9 length 1
    load(2'b00, 13'h0030, "R3 lat3 len1 load");
    burst(1'b0, 9'h155, 0, "R9 len1");

    // R4 rejected loads
    load(2'b00, 13'h0024, "R4 reserved length");
    load(2'b00, 13'h0013, "R4 reserved latency");
    load(2'b00, 13'h00A3, "R4 reserved mode");
    load(2'b00, 13'h002F, "R4 full page interleaved");
    burst(1'b0, 9'h155, 0, "R4 old length kept");

    // R8 full page with modulo-512 wrap
    load(2'b00, 13'h0027, "R2 full page load");
    burst(1'b0, 9'h1FE, 5, "R8 full page wrap");
    burst(1'b1, 9'h010, 1, "R8 full page term first beat");

    // R10 single write mode
    load(2'b00, 13'h0223, "R10 single write load");
    burst(1'b1, 9'h1AD, 0, "R10 single write");
    burst(1'b0, 9'h1AD, 0, "R10 read keeps length");

    // R11 restart mid-burst
    load(2'b00, 13'h0023, "R2 seq8 load");
    cmd_rd = 1'b1; cmd_col = 9'h105;
    tick();
    cmd_rd = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(col_out == exp_col(9'h105, 8, 1'b0, k), "R11 first burst", col_out,
          exp_col(9'h105, 8, 1'b0, k));
      if (k == 2) begin cmd_wr = 1'b1; cmd_col = 9'h0F3; end
      tick();
    end
    cmd_wr = 1'b0;
    for (int k = 0; k < 8; k++) begin
      chk(busy && col_out == exp_col(9'h0F3, 8, 1'b0, k), "R11 restarted burst",
          col_out, exp_col(9'h0F3, 8, 1'b0, k));
      tick();
    end
    chk(busy == 1'b0, "R11 end", busy, 0);

    // R12 early term on a fixed burst
    cmd_rd = 1'b1; cmd_col = 9'h040;
    tick();
    cmd_rd = 1'b0;
    tick();
    term = 1'b1;
    tick();
    term = 1'b0;
    chk(busy == 1'b0, "R12 early term", busy, 0);

    // R5 both commands: read wins (single write mode makes it visible)
    load(2'b00, 13'h0223, "R10 single write load 2");
    cmd_rd = 1'b1; cmd_wr = 1'b1; cmd_col = 9'h0A2;
    tick();
    cmd_rd = 1'b0; cmd_wr = 1'b0;
    for (int k = 0; k < 8; k++) begin
      chk(busy && col_out == exp_col(9'h0A2, 8, 1'b0, k), "R5 read priority",
          col_out, exp_col(9'h0A2, 8, 1'b0, k));
      tick();
    end
    chk(busy == 1'b0, "R5 read priority end", busy, 0);

    // random mix
    for (int i = 0; i < 80; i++) begin
      int pick = int'($urandom % 6);
      if (pick == 0) v = 13'($urandom);
      else begin
        logic [2:0] bl;
        case ($urandom % 5)
          0: bl = 3'b000; 1: bl = 3'b001; 2: bl = 3'b010; 3: bl = 3'b011;
          default: bl = 3'b111;
        endcase
        v = {(($urandom % 2) != 0) ? 6'd4 : 6'd0,
             (($urandom % 2) != 0) ? 3'd3 : 3'd2,
             1'($urandom), bl};
      end
      load(2'(($urandom % 4) == 0 ? $urandom : 0), v, "R4 random load");
      for (int j = 0; j < 3; j++)
        burst(1'($urandom), 9'($urandom), 1 + int'($urandom % 12), "R6 R7 R8 random burst");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule